// File: doc/BRIEF.md
# Serial-Bus Clock-Enable Register Slave

This block is a slave on a two-wire serial bus. It holds seven 8-bit control bytes and turns six of their bits into enables for six clock output pairs. A fast system clock samples SCL and SDA. The block pulls SDA low through an open-drain enable, `sda_oe`; outside the block that pin is wired to pull the line low. The slave has no register addressing.

A write always starts the same way. After the address, two bytes are acknowledged and thrown away. The bytes that follow fill the control bytes in order, starting at byte 0.

A read has no command phase. The slave sends a count byte first and then the control bytes in order.

A START or STOP seen at any point cancels the current transfer.

Top module: `smb_clkctl`

## Requirements
- R1: The slave acknowledges only the address bytes 0xD4 (write) and 0xD5 (read), which is device address 0x6A. Any other address byte gets no acknowledge, and the slave leaves SDA alone until the next START.
- R2: In a write, the slave acknowledges the first two bytes after the address and changes no control byte because of them.
- R3: In a write, the third and later bytes after the address load control bytes 0, 1, 2 … in order. Each byte is acknowledged. A STOP after any complete byte keeps the bytes already loaded and leaves the rest unchanged.
- R4: In a write, bytes beyond control byte 6 are acknowledged and change nothing.
- R5: After a read address, the first byte the slave sends is the count value 7.
- R6: After the count byte, the slave sends control bytes 0 to 6, MSB first. It then sends 0xFF for every further byte the master acknowledges, and stops driving SDA once the master does not acknowledge.
- R7: After reset, control bytes 0 to 5 read 0xFF and byte 6 reads 0x1F.
- R8: `pair_en` bit 0 is control byte 5 bit 7, bit 1 is byte 5 bit 6, bit 2 is byte 5 bit 3, and bit 3 is byte 5 bit 2. Bit 4 is byte 6 bit 3 and bit 5 is byte 6 bit 1. A 1 enables the pair.
- R9: A START during a transfer abandons it, leaves any partly received byte unwritten, and begins a new address phase. A STOP returns the slave to idle with SDA released.
- R10: `sda_oe` is low after reset and while the slave is receiving address or data bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| pair_en | output | 6 | Enables for clock output pairs 0 to 5 |

## Verification
The assertions assume that SCL and SDA change slowly compared with `clk`. Each level must hold for several sampling cycles, so that every edge reaches the state machine as a single-cycle pulse after the synchronizer. They also assume that the master changes SDA only while SCL is low, except to make a START or STOP.

The bench drives a standard-mode-like master. It holds each SCL quarter phase for eight clocks, which is longer than the three-cycle sampling delay, so the slave has released or driven SDA before the master's next change. It models the line as a wired-AND of the master's drive and `sda_oe`.

// File: rtl/smbclk_pkg.sv
package smbclk_pkg;
    localparam int NREG  = 7;
    localparam int NPAIR = 6;
    localparam int AW    = $clog2(NREG);
    localparam logic [6:0] DEV_ADDR = 7'h6A;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_WRX, ST_ACK, ST_TX, ST_MACK, ST_IGNORE
    } xfer_st_t;

    // control byte holding the enable of pair k
    function automatic int pair_byte(int k);
        return (k < 4) ? 5 : 6;
    endfunction

    // bit position of the enable of pair k
    function automatic int pair_bit(int k);
        case (k)
            0:       return 7;
            1:       return 6;
            2:       return 3;
            3:       return 2;
            4:       return 3;
            default: return 1;
        endcase
    endfunction

    function automatic logic [7:0] reg_default(int i);
        return (i == NREG - 1) ? 8'h1F : 8'hFF;
    endfunction
endpackage

// File: rtl/bus_sampler.sv
module bus_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_lvl,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [STAGES-1:0] scl_sync;
        logic [STAGES-1:0] sda_sync;
        logic              scl_prev;
        logic              sda_prev;
    } smp_t;

    smp_t s_d, s_q;
    logic scl_now, sda_now;

    assign scl_now = s_q.scl_sync[STAGES-1];
    assign sda_now = s_q.sda_sync[STAGES-1];

    always_comb begin
        s_d          = s_q;
        s_d.scl_sync = {s_q.scl_sync[STAGES-2:0], scl_in};
        s_d.sda_sync = {s_q.sda_sync[STAGES-2:0], sda_in};
        s_d.scl_prev = scl_now;
        s_d.sda_prev = sda_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign scl_rise  = scl_now & ~s_q.scl_prev;
    assign scl_fall  = ~scl_now & s_q.scl_prev;
    assign sda_lvl   = sda_now;
    assign start_det = scl_now & s_q.scl_prev & s_q.sda_prev & ~sda_now;
    assign stop_det  = scl_now & s_q.scl_prev & ~s_q.sda_prev & sda_now;
endmodule

// File: rtl/smb_xfer_fsm.sv
module smb_xfer_fsm
    import smbclk_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          sda_lvl,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          sda_oe
);
    localparam logic [3:0] LAST_RD = 4'(NREG);
    localparam logic [3:0] LAST_WR = 4'(NREG + 1);

    typedef struct packed {
        xfer_st_t   st;
        logic [3:0] bitcnt;
        logic [7:0] shreg;
        logic [3:0] idx;
        logic       rnw;
        logic       sda_oe;
    } fsm_t;

    fsm_t q, n;
    logic [3:0] idx_m1, idx_m2, idx_inc;
    logic [7:0] tx_byte;

    assign idx_m1  = q.idx - 4'd1;
    assign idx_m2  = q.idx - 4'd2;
    assign idx_inc = (q.idx == 4'hF) ? q.idx : q.idx + 4'd1;
    assign rd_addr = idx_m1[AW-1:0];
    assign wr_addr = idx_m2[AW-1:0];
    assign wr_data = q.shreg;
    assign sda_oe  = q.sda_oe;

    always_comb begin
        if (q.idx == 4'd0)         tx_byte = 8'(NREG);
        else if (q.idx <= LAST_RD) tx_byte = rd_data;
        else                       tx_byte = 8'hFF;
    end

    always_comb begin
        n     = q;
        wr_en = 1'b0;
        case (q.st)
            ST_ADDR, ST_WRX: begin
                if (scl_rise && q.bitcnt < 4'd8) begin
                    n.shreg  = {q.shreg[6:0], sda_lvl};
                    n.bitcnt = q.bitcnt + 4'd1;
                end
                if (scl_fall && q.bitcnt == 4'd8) begin
                    if (q.st == ST_ADDR) begin
                        if (q.shreg[7:1] == DEV_ADDR) begin
                            n.rnw    = q.shreg[0];
                            n.sda_oe = 1'b1;
                            n.idx    = 4'd0;
                            n.st     = ST_ACK;
                        end else begin
                            n.st = ST_IGNORE;
                        end
                    end else begin
                        n.sda_oe = 1'b1;
                        n.st     = ST_ACK;
                        n.idx    = idx_inc;
                        wr_en    = (q.idx >= 4'd2) && (q.idx <= LAST_WR);
                    end
                end
            end
            ST_ACK: begin
                if (scl_fall) begin
                    n.bitcnt = 4'd0;
                    n.sda_oe = 1'b0;
                    if (q.rnw) begin
                        n.shreg  = tx_byte;
                        n.sda_oe = ~tx_byte[7];
                        n.idx    = idx_inc;
                        n.st     = ST_TX;
                    end else begin
                        n.st = ST_WRX;
                    end
                end
            end
            ST_TX: begin
                if (scl_rise && q.bitcnt < 4'd8) n.bitcnt = q.bitcnt + 4'd1;
                if (scl_fall) begin
                    if (q.bitcnt == 4'd8) begin
                        n.sda_oe = 1'b0;
                        n.st     = ST_MACK;
                    end else begin
                        n.shreg  = {q.shreg[6:0], 1'b1};
                        n.sda_oe = ~q.shreg[6];
                    end
                end
            end
            ST_MACK: begin
                if (scl_rise && sda_lvl) n.st = ST_IGNORE;
                else if (scl_fall) begin
                    n.bitcnt = 4'd0;
                    n.shreg  = tx_byte;
                    n.sda_oe = ~tx_byte[7];
                    n.idx    = idx_inc;
                    n.st     = ST_TX;
                end
            end
            default: ;
        endcase
        if (start_det) begin
            n.st     = ST_ADDR;
            n.bitcnt = 4'd0;
            n.idx    = 4'd0;
            n.sda_oe = 1'b0;
        end
        if (stop_det) begin
            n.st     = ST_IDLE;
            n.sda_oe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, bitcnt: 4'd0, shreg: 8'd0, idx: 4'd0, rnw: 1'b0, sda_oe: 1'b0};
        else        q <= n;
    end

    assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (q.st == ST_IDLE && !sda_oe));
    assert_start_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (q.st == ST_ADDR && q.bitcnt == 4'd0));
    assert_ignore_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IGNORE) |-> !sda_oe);
    assert_rx_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ADDR || q.st == ST_WRX) |-> !sda_oe);
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
    import smbclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [7:0]       rd_data,
    output logic [NPAIR-1:0] pair_en
);
    logic [7:0] regs_d [NREG];
    logic [7:0] regs_q [NREG];

    always_comb begin
        regs_d = regs_q;
        if (wr_en && 32'(wr_addr) < NREG) regs_d[wr_addr] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= reg_default(i);
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_data = (32'(rd_addr) < NREG) ? regs_q[rd_addr] : 8'hFF;

    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        localparam int BY = pair_byte(k);
        localparam int BI = pair_bit(k);
        assign pair_en[k] = regs_q[BY][BI];
    end

    assert_wr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (32'(wr_addr) < NREG));
    assert_pairs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pair_en));
endmodule

// File: rtl/smb_clkctl.sv
module smb_clkctl
    import smbclk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_oe,
    output logic [NPAIR-1:0] pair_en
);
    logic scl_rise, scl_fall, sda_lvl, start_det, stop_det;
    logic wr_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;

    bus_sampler #(.STAGES(SYNC_STAGES)) i_sampler (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
        .start_det(start_det), .stop_det(stop_det)
    );

    smb_xfer_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_lvl(sda_lvl), .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe)
    );

    ctl_regfile i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pair_en(pair_en)
    );
endmodule

// File: tb/test_smb_clkctl.sv
`timescale 1ns/1ps
module test_smb_clkctl;
    localparam int Q = 8;
    localparam logic [15:0] VECS [4] = '{16'h0000, 16'hCC0A, 16'h8408, 16'h4802};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic [5:0] pair_en;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [7];
    logic [7:0] wbuf [10];
    logic [7:0] rbuf [9];
    logic all_ack;

    always #10 clk = ~clk;
    assign sda_line = sda_oe ? 1'b0 : m_sda;

    smb_clkctl i_smb_clkctl (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
        .sda_oe(sda_oe), .pair_en(pair_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [5:0] exp_pairs(input logic [7:0] b5, input logic [7:0] b6);
        return {b6[1], b6[3], b5[2], b5[3], b5[6], b5[7]};
    endfunction

    task automatic bus_start();
        m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb);
        for (int i = 7; i > 7 - nb; i--) begin
            m_sda = b[i]; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        ack = (sda_line == 1'b0);
        tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        m_sda = 1'b1;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            tick(Q); scl = 1'b1; tick(Q); b = {b[6:0], sda_line}; tick(Q); scl = 1'b0;
        end
        tick(Q); m_sda = mack ? 1'b0 : 1'b1; tick(Q);
        scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q); m_sda = 1'b1;
    endtask

    // address 0xD4, two discarded bytes, then n data bytes from wbuf
    task automatic do_write(input int n);
        logic a;
        all_ack = 1'b1;
        bus_start();
        send_byte(8'hD4, a); all_ack &= a;
        send_byte(8'hA5, a); all_ack &= a;
        send_byte(8'h3C, a); all_ack &= a;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a); all_ack &= a;
            if (i < 7) model[i] = wbuf[i];
        end
        bus_stop();
    endtask

    task automatic do_read();
        logic a;
        bus_start();
        send_byte(8'hD5, a);
        check("R5 read address ack", a, 1'b1);
        for (int i = 0; i < 9; i++) recv_byte(i < 8, rbuf[i]);
        bus_stop();
        check("R10 released after read", sda_oe, 1'b0);
    endtask

    task automatic check_read(input string req);
        do_read();
        check("R5 count byte", rbuf[0], 8'd7);
        for (int i = 0; i < 7; i++) check(req, rbuf[i + 1], model[i]);
        check("R6 byte past end", rbuf[8], 8'hFF);
    endtask

    task automatic reset_dut();
        rst_n = 1'b0; tick(4); rst_n = 1'b1; tick(4);
        for (int i = 0; i < 6; i++) model[i] = 8'hFF;
        model[6] = 8'h1F;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic a;
        reset_dut();
        check("R7 reset pair enables", pair_en, 6'h3F);
        check("R10 reset sda_oe", sda_oe, 1'b0);

        // table of control-byte patterns
        foreach (VECS[v]) begin
            for (int i = 0; i < 5; i++) wbuf[i] = 8'h10 + 8'(i) + 8'(v);
            wbuf[5] = VECS[v][15:8];
            wbuf[6] = VECS[v][7:0];
            do_write(7);
            check("R2 R3 write acks", all_ack, 1'b1);
            check("R8 pair enables", pair_en, exp_pairs(VECS[v][15:8], VECS[v][7:0]));
            check_read("R3 R6 readback");
        end

        // defaults after reset
        reset_dut();
        check_read("R7 default bytes");

        // foreign addresses are ignored
        bus_start();
        send_byte(8'hA0, a);
        check("R1 foreign address nack", a, 1'b0);
        send_byte(8'h00, a);
        check("R1 ignored until start", a, 1'b0);
        bus_stop();
        bus_start();
        send_byte(8'hD6, a);
        check("R1 near address nack", a, 1'b0);
        bus_stop();
        check("R1 pairs unchanged", pair_en, 6'h3F);

        // partial write keeps the tail
        wbuf[0] = 8'h00; wbuf[1] = 8'h11;
        do_write(2);
        check("R3 partial acks", all_ack, 1'b1);
        check_read("R3 partial write");

        // overrun write
        for (int i = 0; i < 10; i++) wbuf[i] = 8'h40 + 8'(i);
        wbuf[5] = 8'h00; wbuf[6] = 8'h08;
        do_write(10);
        check("R4 extra bytes acked", all_ack, 1'b1);
        check("R4 R8 pairs after overrun", pair_en, 6'b010000);
        check_read("R4 overrun discarded");

        // start in the middle of a data byte
        bus_start();
        send_byte(8'hD4, a);
        send_byte(8'h01, a);
        send_byte(8'h02, a);
        send_bits(8'h00, 3);
        bus_start();
        send_byte(8'hD5, a);
        check("R9 restart read ack", a, 1'b1);
        recv_byte(1'b1, rbuf[0]);
        recv_byte(1'b0, rbuf[1]);
        bus_stop();
        check("R9 restart count", rbuf[0], 8'd7);
        check("R9 byte0 unchanged", rbuf[1], model[0]);
        check("R9 idle after stop", sda_oe, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule